// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the timing and channel stepping for a monitor ADC. It divides the interface clock by an integer setting to make a one-cycle ADC clock enable. Each conversion lasts a fixed number of those ADC clock periods, and BUSY is held high while a conversion runs. In automatic sequence mode the block walks through the channels whose bits are set in a select mask.

The block pulses an end-of-conversion strobe after every channel. It also pulses an end-of-sequence strobe on the conversion that completes a pass through the mask. A digital sample input stands in for the analog front end. The value on that input is captured when each conversion ends. One cycle after each end-of-sequence, the captured value is presented on the data output together with a one-cycle ready strobe.

Top module: `adc_conv_sequencer`

## Requirements
- R1: `adc_clk_en` is a one-cycle pulse that repeats every N interface clock cycles, where N is `div_set` when `div_set` is 2 or more.
- R2: A `div_set` value of 0 or 1 acts as a divide ratio of 2, so `adc_clk_en` never stays high for two cycles in a row.
- R3: A conversion lasts exactly 26 ADC clock periods. During continuous operation, consecutive `eoc` pulses are 26·N interface clock cycles apart.
- R4: `busy` falls on the same edge on which `eoc` rises. Between two back-to-back conversions, `busy` is low for exactly that one `eoc` cycle, so it is high for 26·N−1 cycles of each period.
- R5: Conversions run only when `seq_mode` is 2'b10 (automatic sequence). With any other code no conversion starts and `busy` stays low.
- R6: Channels are converted in ascending order of the set bits of `chan_mask`, where bit k selects channel address k. After the highest set bit, the order wraps to the lowest set bit. A new run after idle begins at the lowest set bit.
- R7: `eoc` is high for exactly one cycle at the end of every conversion. During that cycle `chan_addr` still shows the channel just converted.
- R8: `eos` is high only together with `eoc`, on the conversion of the highest set bit of the mask, so it fires once per pass.
- R9: In the cycle after `eos`, `data_rdy` is high for one cycle. `data_out` then holds the value `sample_in` had at the clock edge that ended the final conversion of the pass.
- R10: With `chan_mask` all zero, no conversion starts and `busy` stays low. If the mask is cleared during a conversion, that conversion completes with one `eoc` and the block then halts.
- R11: While `rst` is high, every output is driven to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| div_set | input | 8 | Integer ADC clock divide ratio |
| chan_mask | input | 16 | Channel select bitmask, bit k = channel k |
| seq_mode | input | 2 | Sequencer mode, 2'b10 = automatic sequence |
| sample_in | input | 16 | Digital stand-in for the converted value |
| adc_clk_en | output | 1 | One-cycle ADC clock enable pulse |
| busy | output | 1 | High while a conversion is in progress |
| chan_addr | output | 4 | Channel being converted |
| eoc | output | 1 | End-of-conversion pulse |
| eos | output | 1 | End-of-sequence pulse |
| data_out | output | 16 | Result latched after each pass |
| data_rdy | output | 1 | One-cycle strobe qualifying `data_out` |

## Verification
Some rules hold on every cycle and are checked there. These are the one-cycle width of `eoc` and of the ADC clock enable, `eos` never appearing without `eoc`, `busy` falling only on an `eoc`, `busy` staying low under a zero mask or a non-automatic mode, and `data_rdy` only ever following `eos`. Other behaviours can only be shown by the bench scenarios running several passes at different ratios and masks. These are the exact 26·N spacing of conversions, the busy-high count per period, the ascending channel order with its wrap, the data value presented after a pass, and the clamping of small divide settings.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [1:0] MODE_AUTO = 2'b10;
  localparam int MIN_DIV = 2;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_set,
  output logic             tick
);
  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] cnt;

  // small settings clamp to the minimum legal ratio
  always_comb eff_div = (div_set < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= eff_div - DIV_W'(1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R2
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CONV_CYCLES = 26,
  localparam int CNT_W = $clog2(CONV_CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic active,
  input  logic clear,
  output logic done
);
  logic [CNT_W-1:0] tcnt;

  assign done = active && tick && (tcnt == CNT_W'(CONV_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) tcnt <= '0;
    else if (active && tick) tcnt <= tcnt + CNT_W'(1);
  end

  AST_TCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    tcnt <= CNT_W'(CONV_CYCLES - 1)); // R3
endmodule

// File: rtl/chan_pick.sv
module chan_pick #(
  parameter int MASK_W = 16,
  localparam int ADDR_W = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] first_ch,
  output logic [ADDR_W-1:0] next_ch,
  output logic              is_last
);
  logic [ADDR_W-1:0] above_ch;
  logic              found_above;

  // descending scan: the last hit written is the lowest qualifying bit
  always_comb begin
    first_ch    = '0;
    above_ch    = '0;
    found_above = 1'b0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (mask[i]) first_ch = ADDR_W'(i);
      if (mask[i] && (i > int'(cur))) begin
        above_ch    = ADDR_W'(i);
        found_above = 1'b1;
      end
    end
    next_ch = found_above ? above_ch : first_ch;
    is_last = !found_above;
  end
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int MASK_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 26,
  localparam int ADDR_W = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_set,
  input  logic [MASK_W-1:0] chan_mask,
  input  logic [1:0]        seq_mode,
  input  logic [DATA_W-1:0] sample_in,
  output logic              adc_clk_en,
  output logic              busy,
  output logic [ADDR_W-1:0] chan_addr,
  output logic              eoc,
  output logic              eos,
  output logic [DATA_W-1:0] data_out,
  output logic              data_rdy
);
  logic              tick;
  logic              done;
  logic              active;
  logic              run;
  logic              start;
  logic [ADDR_W-1:0] first_ch;
  logic [ADDR_W-1:0] next_ch;
  logic              ch_last;
  logic [DATA_W-1:0] res_q;

  assign run        = (seq_mode == MODE_AUTO) && (|chan_mask);
  assign start      = !active && run && tick;
  assign adc_clk_en = tick;

  adc_clk_div #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_div (
    .clk(clk), .rst(rst), .div_set(div_set), .tick(tick)
  );

  conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .active(active),
    .clear(start || done), .done(done)
  );

  chan_pick #(.MASK_W(MASK_W)) u_pick (
    .mask(chan_mask), .cur(chan_addr), .first_ch(first_ch),
    .next_ch(next_ch), .is_last(ch_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      busy      <= 1'b0;
      chan_addr <= '0;
      eoc       <= 1'b0;
      eos       <= 1'b0;
      res_q     <= '0;
      data_out  <= '0;
      data_rdy  <= 1'b0;
    end else begin
      eoc      <= done;
      eos      <= done && ch_last;
      data_rdy <= eos;
      if (eos) data_out <= res_q;
      if (done) begin
        res_q <= sample_in;
        busy  <= 1'b0;
        if (!run) active <= 1'b0;
      end else if (start) begin
        active    <= 1'b1;
        busy      <= 1'b1;
        chan_addr <= first_ch;
      end else if (eoc && active) begin
        // one-cycle gap: step to the next channel or halt
        if (run) begin
          busy      <= 1'b1;
          chan_addr <= next_ch;
        end else begin
          active <= 1'b0;
        end
      end
    end
  end

  AST_EOS_IN_EOC: assert property (@(posedge clk) disable iff (rst)
    eos |-> eoc); // R8
  AST_EOC_PULSE: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc); // R7
  AST_BUSY_FALLS_AT_EOC: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> eoc); // R4
  AST_BUSY_LOW_IN_EOC: assert property (@(posedge clk) disable iff (rst)
    eoc |-> !busy); // R4
  AST_ZERO_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (chan_mask == '0 && !busy) |=> !busy); // R10
  AST_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
    (seq_mode != MODE_AUTO && !busy) |=> !busy); // R5
  AST_DRDY_AFTER_EOS: assert property (@(posedge clk) disable iff (rst)
    data_rdy |-> $past(eos)); // R9
endmodule

// File: tb/adc_conv_sequencer_tb.sv
`timescale 1ns/1ps
module adc_conv_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  div_set = 8'd2;
  logic [15:0] chan_mask = 16'h0000;
  logic [1:0]  seq_mode = 2'b00;
  logic [15:0] sample_in = 16'h1234;
  logic        adc_clk_en, busy, eoc, eos, data_rdy;
  logic [3:0]  chan_addr;
  logic [15:0] data_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_conv_sequencer u_dut (
    .clk(clk), .rst(rst), .div_set(div_set), .chan_mask(chan_mask),
    .seq_mode(seq_mode), .sample_in(sample_in), .adc_clk_en(adc_clk_en),
    .busy(busy), .chan_addr(chan_addr), .eoc(eoc), .eos(eos),
    .data_out(data_out), .data_rdy(data_rdy)
  );

  // {div[7:0], mask[15:0], mode[1:0]}
  localparam int NVEC = 8;
  localparam logic [25:0] VEC [NVEC] = '{
    {8'd0,  16'h0401, 2'b10},
    {8'd1,  16'h8001, 2'b10},
    {8'd10, 16'h0401, 2'b10},
    {8'd3,  16'h00F0, 2'b10},
    {8'd2,  16'h0020, 2'b10},
    {8'd7,  16'h9204, 2'b10},
    {8'd4,  16'h0401, 2'b01},
    {8'd5,  16'h0000, 2'b10}
  };

  function automatic int eff_of(int d);
    return (d < 2) ? 2 : d;
  endfunction

  function automatic int next_sel(logic [15:0] m, int cur);
    for (int i = cur + 1; i < 16; i++) if (m[i]) return i;
    for (int i = 0; i < 16; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic bit none_above(logic [15:0] m, int cur);
    for (int i = cur + 1; i < 16; i++) if (m[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(logic [7:0] d, logic [15:0] m, logic [1:0] md);
    @(negedge clk);
    rst = 1'b1; div_set = d; chan_mask = m; seq_mode = md;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_eoc(int limit, output int cyc, output int bcnt);
    cyc = 0; bcnt = 0;
    do begin
      @(negedge clk); cyc++;
      if (busy) bcnt++;
    end while (!eoc && cyc < limit);
  endtask

  task automatic run_vec(logic [25:0] v);
    logic [7:0]  d  = v[25:18];
    logic [15:0] m  = v[17:2];
    logic [1:0]  md = v[1:0];
    int eff = eff_of(int'(d));
    int cur = -1;
    int cyc, bcnt, c0, b0, nconv, pc, exp_ch;
    logic [15:0] last_smp;
    do_reset(d, m, md);
    if (md == 2'b10 && m != 16'h0) begin
      cyc = 0;
      while (!adc_clk_en && cyc < 300) begin @(negedge clk); cyc++; end
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (!adc_clk_en && cyc < 300);
      chk((d < 2) ? "R2" : "R1", "tick interval", cyc, eff);
      pc = $countones(m);
      nconv = 2 * pc + 1;
      c0 = 0; b0 = 0;
      for (int k = 0; k < nconv; k++) begin
        wait_eoc(30 * eff + 20, cyc, bcnt);
        cyc += c0; bcnt += b0;
        chk("R7", "eoc seen", int'(eoc), 1);
        exp_ch = next_sel(m, cur);
        chk("R6", "channel order", int'(chan_addr), exp_ch);
        chk("R8", "eos flag", int'(eos), int'(none_above(m, exp_ch)));
        if (k > 0) begin
          chk("R3", "eoc spacing", cyc, 26 * eff);
          chk("R4", "busy high cycles", bcnt, 26 * eff - 1);
        end
        cur = exp_ch;
        last_smp = sample_in;
        sample_in = sample_in + 16'h0137;
        c0 = 0; b0 = 0;
        if (eos) begin
          @(negedge clk);
          chk("R9", "data_rdy", int'(data_rdy), 1);
          chk("R9", "data_out", int'(data_out), int'(last_smp));
          chk("R7", "eoc width", int'(eoc), 0);
          c0 = 1; b0 = busy ? 1 : 0;
        end
      end
    end else begin
      cyc = 0;
      for (int i = 0; i < 60 * eff; i++) begin
        @(negedge clk);
        if (busy || eoc) cyc++;
      end
      chk((md != 2'b10) ? "R5" : "R10", "idle activity", cyc, 0);
    end
  endtask

  initial begin
    #(100000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc, bcnt, n;
    // R11: reset state with a running configuration applied
    div_set = 8'd2; chan_mask = 16'h0401; seq_mode = 2'b10;
    repeat (4) @(negedge clk);
    chk("R11", "reset outputs",
        int'({adc_clk_en, busy, eoc, eos, data_rdy}), 0);
    chk("R11", "reset chan/data", int'(chan_addr) + int'(data_out), 0);

    for (int v = 0; v < NVEC; v++) run_vec(VEC[v]);

    // R10: mask cleared during a conversion -> it finishes, then halts
    do_reset(8'd2, 16'h0003, 2'b10);
    cyc = 0;
    while (!busy && cyc < 100) begin @(negedge clk); cyc++; end
    repeat (5) @(negedge clk);
    chan_mask = 16'h0000;
    n = 0; bcnt = 0;
    for (int i = 0; i < 26 * 2 * 3; i++) begin
      @(negedge clk);
      if (eoc) n++;
      if (n > 0 && !eoc && busy) bcnt++;
    end
    chk("R10", "eoc after clear", n, 1);
    chk("R10", "busy after halt", bcnt, 0);

    // R5: leaving auto mode at the eoc gap halts further conversions
    do_reset(8'd2, 16'h0003, 2'b10);
    wait_eoc(200, cyc, bcnt);
    seq_mode = 2'b11;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (busy || eoc) n++;
    end
    chk("R5", "halt on mode change", n, 0);

    // R11: reset asserted mid-conversion clears outputs
    do_reset(8'd3, 16'h0401, 2'b10);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R11", "reset mid-run busy", int'(busy), 0);
    chk("R11", "reset mid-run chan", int'(chan_addr), 0);
    rst = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule